// File: doc/BRIEF.md
# B-Channel Transmit Gating Control

This block sits between the serial timeslot interface and the line modulator of a basic-rate S/T line transceiver. It decides, one octet at a time, whether the B1 and B2 bearer octets go onto the line or are replaced by an all-ones idle octet. The decision depends on three things: a small control register, the operating side (network or terminal), and the INFO signal the transceiver is currently sending. Received B octets pass straight through to the receive serial output and are never gated.

The meaning of the channel control bits depends on the side. On the network side a set bit idles its channel, so the channels carry data after reset. On the terminal side a set bit enables its channel, so the channels stay idle after reset. A second register holds a loop deactivation request, which only the network side may raise. The request goes to the activation state machine and clears itself when that machine acknowledges it.

Each channel runs a two-state machine. `CH_IDLE` moves to `CH_LIVE` on an octet strobe when the channel is allowed, and `CH_LIVE` moves to `CH_IDLE` on an octet strobe when it is not. The deactivation request runs a two-state machine as well. `DR_CLEAR` moves to `DR_PENDING` on a network-side write of 1 with no acknowledge in the same cycle. `DR_PENDING` returns to `DR_CLEAR` on an acknowledge, or when the mode changes to the terminal side. A software reset forces every machine back to `CH_IDLE` or `DR_CLEAR`.

Top module: `bchan_gate`

## Requirements
- R1: After a hardware reset, both channel control bits and the deactivation request read 0, `deact_req` is 0, and `tx_oct_out` is all ones (16'hFFFF).
- R2: On the network side (`is_nt`=1) while `tx_info`=4, a channel whose control bit is 0 transmits its strobed octet, and a channel whose bit is 1 transmits 8'hFF.
- R3: On the terminal side (`is_nt`=0) while `tx_info`=3, a channel whose control bit is 1 transmits its strobed octet, and a channel whose bit is 0 transmits 8'hFF.
- R4: B data is transmitted only while `tx_info` equals 4 on the network side or 3 on the terminal side. In every other case both channels transmit 8'hFF. `tx_info` carries the number of the INFO signal being sent (0 to 4).
- R5: Register address 0 holds the channel control. Bit 3 controls B1, which is `tx_oct_in[7:0]`/`tx_oct_out[7:0]`. Bit 2 controls B2, which is bits [15:8]. The other bits read as 0.
- R6: `rx_oct_out` always equals `rx_oct_in`, whatever the mode, line state or control bits.
- R7: On the network side, writing 1 to bit 2 of address 1 raises `deact_req` in the cycle after the write, and the bit reads back as 1.
- R8: `deact_ack` clears the request in the next cycle. An acknowledge in the same cycle as a setting write leaves the request at 0.
- R9: On the terminal side the deactivation write is ignored, and a pending request drops in the cycle after `is_nt` goes low.
- R10: `sw_rst` clears both channel bits and the deactivation request, and sets `tx_oct_out` to 16'hFFFF, from the next cycle on. It wins over a write made in the same cycle.
- R11: `tx_oct_out` changes only in the cycle after `oct_strobe` (or after a reset). A register write between strobes leaves it unchanged until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| sw_rst | input | 1 | Synchronous software reset |
| is_nt | input | 1 | 1 = network side, 0 = terminal side |
| tx_info | input | 3 | Number of the INFO signal being sent |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Register write enable |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| deact_ack | input | 1 | Activation machine has taken the deactivation |
| deact_req | output | 1 | Deactivation request to the activation machine |
| oct_strobe | input | 1 | Octet boundary: new transmit octets are valid |
| tx_oct_in | input | 16 | Transmit octets from the timeslot interface, B1 in the low byte |
| tx_oct_out | output | 16 | Gated transmit octets to the modulator |
| rx_oct_in | input | 16 | Demodulated receive octets |
| rx_oct_out | output | 16 | Receive octets to the serial output |

## Verification
The gating is tried with different octet values on B1 and B2, so a swapped or mirrored channel mapping shows up as a wrong byte. Every combination of control bits is applied on both sides, which separates the inverted meaning of the bits on the network side from the direct meaning on the terminal side. Each INFO code is swept on each side, which shows that only the matching INFO signal opens the path. A control write placed between two strobes separates gating at the octet boundary from immediate gating, and an acknowledge placed in the same cycle as a setting write checks the collision rule of the self-clearing request.

// File: rtl/bgate_pkg.sv
package bgate_pkg;
    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_LIVE = 1'b1
    } ch_state_e;

    typedef enum logic {
        DR_CLEAR   = 1'b0,
        DR_PENDING = 1'b1
    } dr_state_e;

    localparam int unsigned REG_CHAN    = 0;
    localparam int unsigned REG_DEACT   = 1;
    localparam int unsigned CH_BIT_TOP  = 3;  // B1 control bit, B2 sits one below
    localparam int unsigned DEACT_BIT   = 2;
    localparam int unsigned INFO_NT_DATA = 4;
    localparam int unsigned INFO_TE_DATA = 3;
endpackage

// File: rtl/bgate_regs.sv
module bgate_regs
    import bgate_pkg::*;
#(
    parameter int unsigned NUM_CH = 2,
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              deact_state,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NUM_CH-1:0] chan_bits,
    output logic              deact_set
);
    logic [NUM_CH-1:0] chan_q;
    logic              hit_chan;
    logic              hit_deact;

    always_comb begin
        hit_chan  = (reg_addr == ADDR_W'(REG_CHAN));
        hit_deact = (reg_addr == ADDR_W'(REG_DEACT));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_q <= '0;
        end else if (sw_rst) begin
            chan_q <= '0;
        end else if (reg_wr && hit_chan) begin
            for (int k = 0; k < NUM_CH; k++) begin
                chan_q[k] <= reg_wdata[CH_BIT_TOP-k];
            end
        end
    end

    always_comb begin
        deact_set = reg_wr && hit_deact && reg_wdata[DEACT_BIT];
    end

    always_comb begin
        reg_rdata = '0;
        if (hit_chan) begin
            for (int k = 0; k < NUM_CH; k++) begin
                reg_rdata[CH_BIT_TOP-k] = chan_q[k];
            end
        end else if (hit_deact) begin
            reg_rdata[DEACT_BIT] = deact_state;
        end
    end

    assign chan_bits = chan_q;
endmodule

// File: rtl/bgate_deact_fsm.sv
module bgate_deact_fsm
    import bgate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sw_rst,
    input  logic is_nt,
    input  logic set_req,
    input  logic ack,
    output logic req
);
    dr_state_e state_q;
    dr_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DR_CLEAR;
        end else if (sw_rst) begin
            state_q <= DR_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DR_CLEAR: begin
                if (set_req && is_nt && !ack) begin
                    state_d = DR_PENDING;
                end
            end
            DR_PENDING: begin
                if (ack || !is_nt) begin
                    state_d = DR_CLEAR;
                end
            end
            default: state_d = DR_CLEAR;
        endcase
    end

    always_comb begin
        req = (state_q == DR_PENDING);
    end
endmodule

// File: rtl/bgate_chan_fsm.sv
module bgate_chan_fsm
    import bgate_pkg::*;
#(
    parameter int unsigned OCT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_rst,
    input  logic             strobe,
    input  logic             allow,
    input  logic [OCT_W-1:0] oct_in,
    output logic [OCT_W-1:0] oct_out
);
    localparam logic [OCT_W-1:0] IDLE_OCT = {OCT_W{1'b1}};

    ch_state_e        state_q;
    ch_state_e        state_d;
    logic [OCT_W-1:0] data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
            data_q  <= IDLE_OCT;
        end else if (sw_rst) begin
            state_q <= CH_IDLE;
            data_q  <= IDLE_OCT;
        end else begin
            state_q <= state_d;
            if (strobe) begin
                data_q <= oct_in;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: begin
                if (strobe && allow) begin
                    state_d = CH_LIVE;
                end
            end
            CH_LIVE: begin
                if (strobe && !allow) begin
                    state_d = CH_IDLE;
                end
            end
            default: state_d = CH_IDLE;
        endcase
    end

    always_comb begin
        oct_out = (state_q == CH_LIVE) ? data_q : IDLE_OCT;
    end
endmodule

// File: rtl/bchan_gate.sv
module bchan_gate
    import bgate_pkg::*;
#(
    parameter int unsigned NUM_CH = 2,
    parameter int unsigned OCT_W  = 8,
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned INFO_W = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sw_rst,
    input  logic                      is_nt,
    input  logic [INFO_W-1:0]         tx_info,
    input  logic [ADDR_W-1:0]         reg_addr,
    input  logic                      reg_wr,
    input  logic [DATA_W-1:0]         reg_wdata,
    output logic [DATA_W-1:0]         reg_rdata,
    input  logic                      deact_ack,
    output logic                      deact_req,
    input  logic                      oct_strobe,
    input  logic [NUM_CH*OCT_W-1:0]   tx_oct_in,
    output logic [NUM_CH*OCT_W-1:0]   tx_oct_out,
    input  logic [NUM_CH*OCT_W-1:0]   rx_oct_in,
    output logic [NUM_CH*OCT_W-1:0]   rx_oct_out
);
    logic [NUM_CH-1:0] chan_bits;
    logic [NUM_CH-1:0] chan_allow;
    logic              deact_set;
    logic              info_open;

    bgate_regs #(
        .NUM_CH(NUM_CH),
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_rst     (sw_rst),
        .reg_addr   (reg_addr),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .deact_state(deact_req),
        .reg_rdata  (reg_rdata),
        .chan_bits  (chan_bits),
        .deact_set  (deact_set)
    );

    bgate_deact_fsm u_deact (
        .clk    (clk),
        .rst_n  (rst_n),
        .sw_rst (sw_rst),
        .is_nt  (is_nt),
        .set_req(deact_set),
        .ack    (deact_ack),
        .req    (deact_req)
    );

    always_comb begin
        if (is_nt) begin
            info_open = (tx_info == INFO_W'(INFO_NT_DATA));
        end else begin
            info_open = (tx_info == INFO_W'(INFO_TE_DATA));
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        always_comb begin
            chan_allow[g] = info_open && (is_nt ? !chan_bits[g] : chan_bits[g]);
        end

        bgate_chan_fsm #(
            .OCT_W(OCT_W)
        ) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .sw_rst (sw_rst),
            .strobe (oct_strobe),
            .allow  (chan_allow[g]),
            .oct_in (tx_oct_in[g*OCT_W +: OCT_W]),
            .oct_out(tx_oct_out[g*OCT_W +: OCT_W])
        );
    end

    assign rx_oct_out = rx_oct_in;
endmodule

// File: rtl/bchan_gate_chk.sv
module bchan_gate_chk #(
    parameter int unsigned NUM_CH = 2,
    parameter int unsigned OCT_W  = 8,
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned INFO_W = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    sw_rst,
    input logic                    is_nt,
    input logic [INFO_W-1:0]       tx_info,
    input logic [ADDR_W-1:0]       reg_addr,
    input logic                    reg_wr,
    input logic [DATA_W-1:0]       reg_wdata,
    input logic                    deact_ack,
    input logic                    deact_req,
    input logic                    oct_strobe,
    input logic [NUM_CH*OCT_W-1:0] tx_oct_out
);
    localparam logic [NUM_CH*OCT_W-1:0] ALL_IDLE = '1;

    logic data_phase;
    always_comb begin
        data_phase = is_nt ? (tx_info == INFO_W'(4)) : (tx_info == INFO_W'(3));
    end

    a_r4_closed_idles: assert property (@(posedge clk) disable iff (!rst_n)
        (oct_strobe && !data_phase) |=> (tx_oct_out == ALL_IDLE));

    a_r7_nt_write_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (is_nt && reg_wr && reg_addr == ADDR_W'(1) && reg_wdata[2] && !deact_ack && !sw_rst)
        |=> deact_req);

    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        deact_ack |=> !deact_req);

    a_r9_te_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        !is_nt |=> !deact_req);

    a_r10_swrst_clears: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> (!deact_req && tx_oct_out == ALL_IDLE));

    a_r11_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        (!oct_strobe && !sw_rst) |=> $stable(tx_oct_out));
endmodule

bind bchan_gate bchan_gate_chk #(
    .NUM_CH(NUM_CH),
    .OCT_W (OCT_W),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .INFO_W(INFO_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_rst    (sw_rst),
    .is_nt     (is_nt),
    .tx_info   (tx_info),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .deact_ack (deact_ack),
    .deact_req (deact_req),
    .oct_strobe(oct_strobe),
    .tx_oct_out(tx_oct_out)
);

// File: tb/bchan_gate_tb.sv
module bchan_gate_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_rst = 1'b0;
    logic        is_nt = 1'b1;
    logic [2:0]  tx_info = 3'd0;
    logic [1:0]  reg_addr = 2'd0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [7:0]  reg_rdata;
    logic        deact_ack = 1'b0;
    logic        deact_req;
    logic        oct_strobe = 1'b0;
    logic [15:0] tx_oct_in = 16'd0;
    logic [15:0] tx_oct_out;
    logic [15:0] rx_oct_in = 16'd0;
    logic [15:0] rx_oct_out;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    bchan_gate u_dut (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .is_nt(is_nt), .tx_info(tx_info),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .deact_ack(deact_ack), .deact_req(deact_req), .oct_strobe(oct_strobe),
        .tx_oct_in(tx_oct_in), .tx_oct_out(tx_oct_out),
        .rx_oct_in(rx_oct_in), .rx_oct_out(rx_oct_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] a, input logic [7:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(tag, {24'd0, reg_rdata}, {24'd0, exp});
    endtask

    task automatic strobe(input logic [15:0] d);
        @(negedge clk);
        tx_oct_in = d; oct_strobe = 1'b1;
        @(negedge clk);
        oct_strobe = 1'b0;
    endtask

    function automatic logic [15:0] expect_out(input logic nt, input logic [2:0] info,
                                                input logic [7:0] ctl, input logic [15:0] d);
        logic [15:0] r;
        logic open_ph;
        logic en1, en2;
        open_ph = nt ? (info == 3'd4) : (info == 3'd3);
        en1 = nt ? !ctl[3] : ctl[3];
        en2 = nt ? !ctl[2] : ctl[2];
        r[7:0]  = (open_ph && en1) ? d[7:0]  : 8'hFF;
        r[15:8] = (open_ph && en2) ? d[15:8] : 8'hFF;
        return r;
    endfunction

    task automatic t_reset();
        @(negedge clk);
        chk("R1 tx idle", {16'd0, tx_oct_out}, 32'h0000FFFF);
        chk("R1 deact_req", {31'd0, deact_req}, 32'd0);
        rd_chk("R1 chan reg", 2'd0, 8'h00);
        rd_chk("R1 deact reg", 2'd1, 8'h00);
    endtask

    task automatic t_nt_gating();
        is_nt = 1'b1; tx_info = 3'd4;
        for (int c = 0; c < 4; c++) begin
            logic [7:0] ctl;
            ctl = 8'(c << 2);
            wr(2'd0, ctl);
            strobe(16'h5AC3 ^ 16'(c * 16'h1111));
            chk("R2 nt gating", {16'd0, tx_oct_out},
                {16'd0, expect_out(1'b1, 3'd4, ctl, 16'h5AC3 ^ 16'(c * 16'h1111))});
        end
    endtask

    task automatic t_te_gating();
        is_nt = 1'b0; tx_info = 3'd3;
        for (int c = 0; c < 4; c++) begin
            logic [7:0] ctl;
            ctl = 8'(c << 2);
            wr(2'd0, ctl);
            strobe(16'h96E1 ^ 16'(c * 16'h0101));
            chk("R3 te gating", {16'd0, tx_oct_out},
                {16'd0, expect_out(1'b0, 3'd3, ctl, 16'h96E1 ^ 16'(c * 16'h0101))});
        end
    endtask

    task automatic t_info_gating();
        for (int side = 0; side < 2; side++) begin
            is_nt = side[0];
            wr(2'd0, side[0] ? 8'h00 : 8'h0C);
            for (int i = 0; i < 5; i++) begin
                tx_info = 3'(i);
                strobe(16'h1234);
                chk("R4 info gating", {16'd0, tx_oct_out},
                    {16'd0, expect_out(side[0], 3'(i), side[0] ? 8'h00 : 8'h0C, 16'h1234)});
            end
        end
    endtask

    task automatic t_map_readback();
        is_nt = 1'b1; tx_info = 3'd4;
        wr(2'd0, 8'hFF);
        rd_chk("R5 readback mask", 2'd0, 8'h0C);
        wr(2'd0, 8'h08);
        rd_chk("R5 readback b1", 2'd0, 8'h08);
        strobe(16'hBEEF);
        chk("R5 bit3 is B1", {16'd0, tx_oct_out}, 32'h0000BEFF);
        wr(2'd0, 8'h04);
        strobe(16'hBEEF);
        chk("R5 bit2 is B2", {16'd0, tx_oct_out}, 32'h0000FFEF);
        rd_chk("R5 unused addr", 2'd2, 8'h00);
    endtask

    task automatic t_rx_pass();
        is_nt = 1'b0; tx_info = 3'd0;
        wr(2'd0, 8'h00);
        @(negedge clk); rx_oct_in = 16'hA55A; #1;
        chk("R6 rx te idle", {16'd0, rx_oct_out}, 32'h0000A55A);
        is_nt = 1'b1; wr(2'd0, 8'h0C);
        @(negedge clk); rx_oct_in = 16'h0F3C; #1;
        chk("R6 rx nt idle", {16'd0, rx_oct_out}, 32'h00000F3C);
    endtask

    task automatic t_deact();
        is_nt = 1'b1;
        wr(2'd1, 8'h04);
        chk("R7 req raised", {31'd0, deact_req}, 32'd1);
        rd_chk("R7 readback", 2'd1, 8'h04);
        @(negedge clk); deact_ack = 1'b1;
        @(negedge clk); deact_ack = 1'b0;
        chk("R8 ack clears", {31'd0, deact_req}, 32'd0);
    endtask

    task automatic t_deact_collide();
        is_nt = 1'b1;
        @(negedge clk);
        reg_addr = 2'd1; reg_wdata = 8'h04; reg_wr = 1'b1; deact_ack = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; deact_ack = 1'b0;
        chk("R8 collide", {31'd0, deact_req}, 32'd0);
        rd_chk("R8 collide readback", 2'd1, 8'h00);
    endtask

    task automatic t_te_deact();
        is_nt = 1'b0;
        wr(2'd1, 8'h04);
        chk("R9 te write ignored", {31'd0, deact_req}, 32'd0);
        rd_chk("R9 te readback", 2'd1, 8'h00);
        is_nt = 1'b1;
        wr(2'd1, 8'h04);
        chk("R9 nt pending", {31'd0, deact_req}, 32'd1);
        @(negedge clk); is_nt = 1'b0;
        @(negedge clk);
        chk("R9 te drops pending", {31'd0, deact_req}, 32'd0);
    endtask

    task automatic t_swrst();
        is_nt = 1'b1; tx_info = 3'd4;
        wr(2'd0, 8'h04);
        wr(2'd1, 8'h04);
        strobe(16'h7788);
        chk("R10 pre data", {16'd0, tx_oct_out}, 32'h0000FF88);
        @(negedge clk);
        sw_rst = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h0C; reg_wr = 1'b1;
        @(negedge clk);
        sw_rst = 1'b0; reg_wr = 1'b0;
        chk("R10 tx idle", {16'd0, tx_oct_out}, 32'h0000FFFF);
        chk("R10 req cleared", {31'd0, deact_req}, 32'd0);
        rd_chk("R10 chan cleared", 2'd0, 8'h00);
    endtask

    task automatic t_octet_boundary();
        is_nt = 1'b1; tx_info = 3'd4;
        wr(2'd0, 8'h00);
        strobe(16'h3CA5);
        chk("R11 first octet", {16'd0, tx_oct_out}, 32'h00003CA5);
        wr(2'd0, 8'h08);
        @(negedge clk);
        chk("R11 held after write", {16'd0, tx_oct_out}, 32'h00003CA5);
        @(negedge clk); tx_oct_in = 16'h1122;
        @(negedge clk);
        chk("R11 no strobe no change", {16'd0, tx_oct_out}, 32'h00003CA5);
        strobe(16'h1122);
        chk("R11 next octet gated", {16'd0, tx_oct_out}, 32'h000011FF);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_nt_gating();
        t_te_gating();
        t_info_gating();
        t_map_readback();
        t_rx_pass();
        t_deact();
        t_deact_collide();
        t_te_deact();
        t_swrst();
        t_octet_boundary();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule